// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Detector

This block compares a reference logic signal against a feedback signal taken from a loop oscillator's divided output, and issues a three-valued pump command for a downstream charge pump and loop filter. Both inputs are asynchronous to the block. Each one passes through a multi-flop synchroniser and a rising-edge detector, so only positive-going transitions matter. The high and low times of either input have no influence on the result.

A reference edge that arrives before the matching feedback edge makes the block source (pump up) until the feedback edge shows up. The opposite order makes it sink (pump down). Edges that arrive together leave it idle, which is the high-impedance state. If the reference runs faster than the feedback, several reference edges arrive per feedback edge, so sourcing wins on average. A slower reference gives sinking. This makes the detector sensitive to frequency as well as phase.

A lock output counts consecutive reference edges in which no pump pulse lasts longer than one system clock. It goes high once the count reaches a parameter, and it is masked low whenever a pulse is active.

Top module: `edge_pfd`

## Requirements
- R1: Only rising edges of `ref_in` and `fbk_in` change the pump state. Falling edges and the length of the high or low time have no effect on the pump outputs.
- R2: Exactly one of `pump_up`, `pump_dn` and `pump_hiz` is 1 in every cycle. `pump_up` and `pump_dn` are never 1 together, and `pump_hiz` is 1 exactly when neither of them is.
- R3: When a `ref_in` rise leads an `fbk_in` rise by d clock cycles (inputs changing between clock edges), `pump_up` is high for exactly d cycles, and the block then returns to idle.
- R4: When an `fbk_in` rise leads a `ref_in` rise by d cycles, `pump_dn` is high for exactly d cycles, and the block then returns to idle.
- R5: When both inputs rise in the same cycle, the pump stays idle throughout.
- R6: If a second `ref_in` rise arrives while the block is sourcing, sourcing continues without a break until the next `fbk_in` rise. Sinking behaves the same way with the roles of the two inputs swapped.
- R7: `lock_out` is 0 in every cycle in which `pump_up` or `pump_dn` is 1.
- R8: `lock_out` goes to 1 once LOCK_PERIODS `ref_in` rises have been counted since reset, or since the last pump pulse longer than one clock. Such a long pulse clears the count. The count saturates at LOCK_PERIODS, and one-cycle pulses do not clear it.
- R9: A synchronous active-high `rst` forces the pump idle, clears the edge state and the lock count, and holds `lock_out` at 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either input |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal, asynchronous |
| fbk_in | input | 1 | Feedback signal from the oscillator divider, asynchronous |
| pump_up | output | 1 | Source command |
| pump_dn | output | 1 | Sink command |
| pump_hiz | output | 1 | Idle (high-impedance) command |
| lock_out | output | 1 | In-lock indicator |

## Verification
The assertions assume that each input level lasts long enough for the synchroniser to capture it, so that every rise appears as exactly one detected edge. They also assume that inputs are low, or are lowered, before reset is released. The stimulus changes the inputs only on the falling clock edge and keeps every high and low phase at least two cycles long. It also lowers both inputs while reset is held. Under these conditions, a pulse width measured in clock cycles equals the programmed phase offset exactly.

// File: rtl/edge_pfd_pkg.sv
package edge_pfd_pkg;
   typedef enum logic [1:0] {
      PUMP_IDLE = 2'b00,
      PUMP_SRC  = 2'b01,
      PUMP_SNK  = 2'b10
   } pump_e;
endpackage

// File: rtl/edge_pfd_sync.sv
module edge_pfd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/edge_pfd_pump.sv
module edge_pfd_pump
   import edge_pfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  ref_edge,
   input  logic  fbk_edge,
   output pump_e state
);
   logic want_src, want_snk;
   pump_e nxt;

   always_comb begin
      want_src = (state == PUMP_SRC) | ref_edge;
      want_snk = (state == PUMP_SNK) | fbk_edge;
      case ({want_snk, want_src})
         2'b01:   nxt = PUMP_SRC;
         2'b10:   nxt = PUMP_SNK;
         default: nxt = PUMP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= PUMP_IDLE;
      else     state <= nxt;
   end
endmodule

// File: rtl/edge_pfd_lock.sv
module edge_pfd_lock #(
   parameter int PERIODS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_edge,
   input  logic active,
   output logic reached
);
   localparam int CW = $clog2(PERIODS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(PERIODS);

   logic [CW-1:0] cnt;
   logic          active_d;
   logic          long_pulse;

   assign long_pulse = active & active_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         active_d <= 1'b0;
      end else begin
         active_d <= active;
         if (long_pulse)
            cnt <= '0;
         else if (ref_edge && cnt != LIMIT)
            cnt <= cnt + 1'b1;
      end
   end

   assign reached = (cnt == LIMIT);
endmodule

// File: rtl/edge_pfd.sv
module edge_pfd
   import edge_pfd_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int LOCK_PERIODS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_in,
   input  logic fbk_in,
   output logic pump_up,
   output logic pump_dn,
   output logic pump_hiz,
   output logic lock_out
);
   localparam int N_IN = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOCK_PERIODS < 1) begin : g_bad_lock
      $error("LOCK_PERIODS must be at least 1");
   end

   logic [N_IN-1:0] raw_in, rise_vec;
   logic            ref_rise, fbk_rise;
   pump_e           pstate;
   logic            lock_reached;

   assign raw_in = {fbk_in, ref_in};

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      edge_pfd_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk  (clk),
         .rst  (rst),
         .din  (raw_in[i]),
         .rise (rise_vec[i])
      );
   end

   assign ref_rise = rise_vec[0];
   assign fbk_rise = rise_vec[1];

   edge_pfd_pump pump_i (
      .clk      (clk),
      .rst      (rst),
      .ref_edge (ref_rise),
      .fbk_edge (fbk_rise),
      .state    (pstate)
   );

   assign pump_up  = (pstate == PUMP_SRC);
   assign pump_dn  = (pstate == PUMP_SNK);
   assign pump_hiz = (pstate == PUMP_IDLE);

   edge_pfd_lock #(.PERIODS(LOCK_PERIODS)) lock_i (
      .clk      (clk),
      .rst      (rst),
      .ref_edge (ref_rise),
      .active   (pump_up | pump_dn),
      .reached  (lock_reached)
   );

   assign lock_out = lock_reached & pump_hiz;
endmodule

// File: rtl/edge_pfd_checker.sv
module edge_pfd_checker (
   input logic clk,
   input logic rst,
   input logic up,
   input logic dn,
   input logic hiz,
   input logic lock,
   input logic ref_edge,
   input logic fbk_edge
);
   p_one_state_r2: assert property (@(posedge clk) disable iff (rst)
      $countones({up, dn, hiz}) == 1);
   p_no_both_r2: assert property (@(posedge clk) disable iff (rst)
      !(up && dn));
   p_falls_ignored_r1: assert property (@(posedge clk) disable iff (rst)
      (hiz && !ref_edge && !fbk_edge) |=> hiz);
   p_up_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (up && !fbk_edge) |=> up);
   p_up_end_r3: assert property (@(posedge clk) disable iff (rst)
      (up && fbk_edge) |=> hiz);
   p_dn_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (dn && !ref_edge) |=> dn);
   p_dn_end_r4: assert property (@(posedge clk) disable iff (rst)
      (dn && ref_edge) |=> hiz);
   p_together_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (hiz && ref_edge && fbk_edge) |=> hiz);
   p_lock_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (up || dn) |-> !lock);
   p_reset_idle_r9: assert property (@(posedge clk)
      rst |=> (hiz && !lock));
endmodule

bind edge_pfd edge_pfd_checker chk_i (
   .clk      (clk),
   .rst      (rst),
   .up       (pump_up),
   .dn       (pump_dn),
   .hiz      (pump_hiz),
   .lock     (lock_out),
   .ref_edge (ref_rise),
   .fbk_edge (fbk_rise)
);

// File: tb/edge_pfd_tb_top.sv
module edge_pfd_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NLOCK      = 3;
   localparam int WIN        = 30;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_in = 1'b0;
   logic fbk_in = 1'b0;
   logic pump_up, pump_dn, pump_hiz, lock_out;

   int checks = 0;
   int errors = 0;
   int lock_model = 0;
   int up_n, dn_n, bad_n, lockact_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_pfd #(.SYNC_STAGES(2), .LOCK_PERIODS(NLOCK)) dut_i (
      .clk(clk), .rst(rst), .ref_in(ref_in), .fbk_in(fbk_in),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz), .lock_out(lock_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one trial. Times are in cycles from the start; -1 means no second rise.
   task automatic trial(input int r0, input int r1, input int f0, input int f1,
                        input int hr, input int hf);
      up_n = 0; dn_n = 0; bad_n = 0; lockact_n = 0;
      for (int t = 0; t < WIN; t++) begin
         @(negedge clk);
         up_n      += int'(pump_up);
         dn_n      += int'(pump_dn);
         bad_n     += int'(($countones({pump_up, pump_dn, pump_hiz}) != 1) || (pump_up && pump_dn));
         lockact_n += int'(lock_out && (pump_up || pump_dn));
         ref_in = (t >= r0 && t < r0 + hr) || (r1 >= 0 && t >= r1 && t < r1 + hr);
         fbk_in = (t >= f0 && t < f0 + hf) || (f1 >= 0 && t >= f1 && t < f1 + hf);
      end
   endtask

   function automatic void model_lock(input bit long_pulse);
      if (long_pulse) lock_model = 0;
      else if (lock_model < NLOCK) lock_model++;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9 reset state
      check(pump_hiz && !pump_up && !pump_dn, "R9 idle in reset", int'(pump_hiz), 1);
      check(!lock_out, "R9 lock low in reset", int'(lock_out), 0);
      rst = 1'b0;
      @(negedge clk);
      check(!lock_out && pump_hiz, "R9 state after release", int'(lock_out), 0);

      // R3 R4 R5 sweep of phase offsets, varying high times (R1)
      for (int d = -6; d <= 6; d++) begin
         int hr, hf, r0, f0, eu, ed;
         hr = 2 + ((d + 6) % 3);
         hf = 2 + ((d + 7) % 4);
         r0 = 1 + ((d < 0) ? -d : 0);
         f0 = 1 + ((d > 0) ? d : 0);
         eu = (d > 0) ? d : 0;
         ed = (d < 0) ? -d : 0;
         trial(r0, -1, f0, -1, hr, hf);
         model_lock((d > 1) || (d < -1));
         if (d > 0)       check(up_n == eu, "R3 source width", up_n, eu);
         else if (d == 0) check(up_n == 0 && dn_n == 0, "R5 in phase idle", up_n + dn_n, 0);
         else             check(dn_n == ed, "R4 sink width", dn_n, ed);
         if (d >= 0) check(dn_n == 0, "R3 no sink when leading", dn_n, 0);
         else        check(up_n == 0, "R4 no source when lagging", up_n, 0);
         check(bad_n == 0, "R2 exclusive states", bad_n, 0);
         check(pump_hiz, "R3 R4 idle after pulse", int'(pump_hiz), 1);
         check(int'(lock_out) == int'(lock_model == NLOCK), "R8 lock after trial",
               int'(lock_out), int'(lock_model == NLOCK));
      end

      // R1 duty factor ignored: same rise, very different high times
      trial(1, -1, 1, -1, 2, 9);
      model_lock(1'b0);
      check(up_n == 0 && dn_n == 0, "R1 unequal high times", up_n + dn_n, 0);
      trial(1, -1, 1, -1, 10, 3);
      model_lock(1'b0);
      check(up_n == 0 && dn_n == 0, "R1 unequal high times swapped", up_n + dn_n, 0);

      // R6 frequency sensitivity
      trial(1, 6, 11, -1, 2, 2);
      model_lock(1'b1);
      check(up_n == 10 && dn_n == 0, "R6 fast reference sources", up_n, 10);
      check(!lock_out, "R8 long pulse clears lock", int'(lock_out), 0);
      trial(11, -1, 1, 6, 2, 2);
      model_lock(1'b1);
      check(dn_n == 10 && up_n == 0, "R6 fast feedback sinks", dn_n, 10);

      // R8 lock build-up, R7 masking during a short pulse
      for (int k = 1; k <= NLOCK; k++) begin
         trial(1, -1, 1, -1, 3, 3);
         model_lock(1'b0);
         check(int'(lock_out) == int'(k == NLOCK), "R8 lock count", int'(lock_out), int'(k == NLOCK));
      end
      trial(1, -1, 2, -1, 3, 3);
      model_lock(1'b0);
      check(up_n == 1, "R3 one cycle lead", up_n, 1);
      check(lockact_n == 0, "R7 lock low during pulse", lockact_n, 0);
      check(lock_out, "R8 one cycle pulse keeps lock", int'(lock_out), 1);

      // R9 reset in the middle of a pulse
      @(negedge clk);
      ref_in = 1'b1;
      repeat (5) @(negedge clk);
      check(pump_up, "R9 pulse before reset", int'(pump_up), 1);
      rst = 1'b1;
      ref_in = 1'b0;
      @(negedge clk);
      check(pump_hiz && !lock_out, "R9 reset clears pulse", int'(pump_up), 0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      lock_model = 0;
      repeat (6) @(negedge clk);
      check(pump_hiz && !lock_out, "R9 quiet after reset", int'(lock_out), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule